// File: doc/BRIEF.md
# Debug Bus Capture Controller with Selectable Store Path

This block records a burst of samples from a wide parallel debug bus that changes on every clock. A single start pulse begins a capture. The mode is sampled at the start pulse and then selects one of two external stores.

The first store is a FIFO narrower than the bus. On this path the block writes the most significant bits of every sample, so the captured block has no gaps. The second store is a static RAM built from three byte-wide lanes. On this path the block keeps the full sample width, sign-extended to one 24-bit word. Each lane write takes its own strobe, so every stored word needs a six-cycle sequence, and only one sample in six is kept.

When the store is full, the block reports that data is waiting. It then returns the words one at a time in address order through a paced readout port. When the last word has gone out it returns to idle.

Top module: `dbgcap_top`

## Requirements
- R1: After reset `idleRdy` is 1, `dataAvail` is 0, `outValid` is 0, `fifoWrEn` is 0 and `sramWrEn` is 000.
- R2: In FIFO mode (`modeSram`=0 at the start pulse), `fifoWrEn` is high in every one of the 2^ADDR_W cycles that follow the cycle in which the start pulse is accepted. In each of those cycles `fifoWrData` equals `dbgData[19:2]` of that same cycle.
- R3: In RAM mode (`modeSram`=1 at the start pulse), the sample on the bus in capture cycle 6k (cycle 0 is the first cycle after the start is accepted) becomes word k at address k. No other samples are kept.
- R4: A RAM word is the 20-bit sample sign-extended to 24 bits. Lane 0 takes bits 7:0, lane 1 takes bits 15:8 and lane 2 takes bits 23:16. `sramWrEn` has at most one bit set, and the lanes are written in order 0, 1, 2 in consecutive cycles while `sramAddr` holds still.
- R5: Capture stops after exactly 2^ADDR_W words, and `dataAvail` then rises. No further store writes occur.
- R6: Readout presents words in address order starting at address 0. `outValid` is high one cycle per word, two cycles after the read strobe. RAM words appear as stored. FIFO words appear as the 18-bit value sign-extended to 24 bits.
- R7: A read strobe (`fifoRdEn` or `sramRdEn`) is issued only in a cycle where `outReady` is 1.
- R8: `dataAvail` falls in the cycle the last word is presented on `outWord`. `idleRdy` is high in that same cycle, and the two flags are never high together.
- R9: A start pulse during capture or readout is ignored, and so is a change of `modeSram` after the start pulse. The word count, the contents and the readout are unchanged.
- R10: `fifoWrEn` and `sramWrEn` are never active in the same cycle, and neither is active while `idleRdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a capture when idle |
| modeSram | input | 1 | 1 selects the full-width RAM path, 0 the FIFO path; sampled at start |
| dbgData | input | 20 | Debug bus, one new sample every cycle |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 18 | Upper 18 bits of the current sample |
| fifoRdEn | output | 1 | FIFO read strobe; data expected next cycle |
| fifoRdData | input | 18 | FIFO read data |
| sramAddr | output | 15 | RAM word address for writes and reads |
| sramWrEn | output | 3 | Per-lane RAM write strobes |
| sramWrData | output | 8 | Byte for the lane being written |
| sramRdEn | output | 1 | RAM read strobe; data expected next cycle |
| sramRdData | input | 24 | Three lanes read together, lane 2 in the top byte |
| outReady | input | 1 | Consumer can take another word |
| outWord | output | 24 | Readout word |
| outValid | output | 1 | `outWord` holds a new word this cycle |
| idleRdy | output | 1 | Block idle and ready for a start pulse |
| dataAvail | output | 1 | Captured data waiting to be read out |

## Verification
A wrong phase or lane state would show up at once as a lane strobe out of order, or as a byte taken from the wrong slice of the held sample. A phase that drifts against sample acceptance only shows up later, when readout returns words built from samples other than every sixth. A word counter that ends one short or one long shows up when the capture ends: the number of FIFO or lane writes is wrong and `dataAvail` rises a cycle early or late. A lost mode latch mixes FIFO and RAM strobes within a burst and corrupts every word read out afterwards. A start pulse taken while busy restarts the address and shows up as a repeated or short readout.

// File: rtl/dbgcap_pkg.sv
package dbgcap_pkg;
  localparam int LANE_CNT = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_TAKE  = 2'd3
  } capState_e;

  typedef struct packed {
    logic                clrAddr;
    logic                incAddr;
    logic                latchSample;
    logic [LANE_CNT-1:0] laneWe;
    logic                fifoWe;
    logic                rdStrobe;
    logic                takeWord;
  } capStrobes_t;
endpackage

// File: rtl/dbgcap_ctrl.sv
module dbgcap_ctrl
  import dbgcap_pkg::*;
#(
  parameter int PHASES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        modeSram,
  input  logic        outReady,
  input  logic        addrLast,
  output capStrobes_t strobes,
  output logic        modeLat,
  output logic        idleRdy,
  output logic        dataAvail
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  capState_e state;
  logic [PH_W-1:0] phase;
  logic captEnd;

  always_comb begin
    strobes = '0;
    captEnd = 1'b0;
    case (state)
      ST_IDLE: strobes.clrAddr = startPulse;
      ST_CAPT: begin
        if (!modeLat) begin
          strobes.fifoWe  = 1'b1;
          strobes.incAddr = 1'b1;
        end else begin
          strobes.latchSample = (phase == '0);
          for (int i = 0; i < LANE_CNT; i++) begin
            strobes.laneWe[i] = (phase == PH_W'(i + 1));
          end
          strobes.incAddr = (phase == PH_LAST);
        end
        captEnd = strobes.incAddr && addrLast;
        if (captEnd) strobes.clrAddr = 1'b1;
      end
      ST_ISSUE: strobes.rdStrobe = outReady;
      ST_TAKE: begin
        strobes.takeWord = 1'b1;
        strobes.incAddr  = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      modeLat <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase <= '0;
          if (startPulse) begin
            state   <= ST_CAPT;
            modeLat <= modeSram;
          end
        end
        ST_CAPT: begin
          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
          if (captEnd) state <= ST_ISSUE;
        end
        ST_ISSUE: if (outReady) state <= ST_TAKE;
        ST_TAKE:  state <= addrLast ? ST_IDLE : ST_ISSUE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign idleRdy   = (state == ST_IDLE);
  assign dataAvail = (state == ST_ISSUE) || (state == ST_TAKE);
endmodule

// File: rtl/dbgcap_dp.sv
module dbgcap_dp
  import dbgcap_pkg::*;
#(
  parameter int DBG_W  = 20,
  parameter int FIFO_W = 18,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  capStrobes_t                strobes,
  input  logic                       modeLat,
  input  logic [DBG_W-1:0]           dbgData,
  input  logic [FIFO_W-1:0]          fifoRdData,
  input  logic [LANE_CNT*LANE_W-1:0] sramRdData,
  output logic                       addrLast,
  output logic [ADDR_W-1:0]          sramAddr,
  output logic [LANE_CNT-1:0]        sramWrEn,
  output logic [LANE_W-1:0]          sramWrData,
  output logic                       sramRdEn,
  output logic                       fifoWrEn,
  output logic [FIFO_W-1:0]          fifoWrData,
  output logic                       fifoRdEn,
  output logic [LANE_CNT*LANE_W-1:0] outWord,
  output logic                       outValid
);
  localparam int WORD_W = LANE_CNT * LANE_W;

  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] holdWord;
  logic [LANE_W-1:0] laneByte [LANE_CNT];

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    assign laneByte[g] = holdWord[g*LANE_W +: LANE_W];
  end

  always_comb begin
    sramWrData = '0;
    for (int i = 0; i < LANE_CNT; i++) begin
      if (strobes.laneWe[i]) sramWrData = laneByte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr     <= '0;
      holdWord <= '0;
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobes.clrAddr)      addr <= '0;
      else if (strobes.incAddr) addr <= addr + 1'b1;
      if (strobes.latchSample)
        holdWord <= {{(WORD_W-DBG_W){dbgData[DBG_W-1]}}, dbgData};
      if (strobes.takeWord)
        outWord <= modeLat ? sramRdData
                           : {{(WORD_W-FIFO_W){fifoRdData[FIFO_W-1]}}, fifoRdData};
      outValid <= strobes.takeWord;
    end
  end

  assign addrLast   = (addr == {ADDR_W{1'b1}});
  assign sramAddr   = addr;
  assign sramWrEn   = strobes.laneWe;
  assign sramRdEn   = strobes.rdStrobe && modeLat;
  assign fifoRdEn   = strobes.rdStrobe && !modeLat;
  assign fifoWrEn   = strobes.fifoWe;
  assign fifoWrData = dbgData[DBG_W-1 -: FIFO_W];
endmodule

// File: rtl/dbgcap_top.sv
module dbgcap_top
  import dbgcap_pkg::*;
#(
  parameter int DBG_W  = 20,
  parameter int FIFO_W = 18,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 15,
  parameter int PHASES = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  input  logic                       modeSram,
  input  logic [DBG_W-1:0]           dbgData,
  output logic                       fifoWrEn,
  output logic [FIFO_W-1:0]          fifoWrData,
  output logic                       fifoRdEn,
  input  logic [FIFO_W-1:0]          fifoRdData,
  output logic [ADDR_W-1:0]          sramAddr,
  output logic [LANE_CNT-1:0]        sramWrEn,
  output logic [LANE_W-1:0]          sramWrData,
  output logic                       sramRdEn,
  input  logic [LANE_CNT*LANE_W-1:0] sramRdData,
  input  logic                       outReady,
  output logic [LANE_CNT*LANE_W-1:0] outWord,
  output logic                       outValid,
  output logic                       idleRdy,
  output logic                       dataAvail
);
  capStrobes_t strobes;
  logic modeLat;
  logic addrLast;

  dbgcap_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeSram(modeSram),
    .outReady(outReady), .addrLast(addrLast), .strobes(strobes),
    .modeLat(modeLat), .idleRdy(idleRdy), .dataAvail(dataAvail)
  );

  dbgcap_dp #(.DBG_W(DBG_W), .FIFO_W(FIFO_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeLat(modeLat),
    .dbgData(dbgData), .fifoRdData(fifoRdData), .sramRdData(sramRdData),
    .addrLast(addrLast), .sramAddr(sramAddr), .sramWrEn(sramWrEn),
    .sramWrData(sramWrData), .sramRdEn(sramRdEn), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .fifoRdEn(fifoRdEn), .outWord(outWord),
    .outValid(outValid)
  );
endmodule

// File: rtl/dbgcap_chk.sv
module dbgcap_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoWrEn,
  input logic              fifoRdEn,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [2:0]        sramWrEn,
  input logic              sramRdEn,
  input logic              outReady,
  input logic              outValid,
  input logic              idleRdy,
  input logic              dataAvail
);
  p_lane_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sramWrEn));

  p_lane_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    sramWrEn[0] |=> sramWrEn[1] && $stable(sramAddr));

  p_lane_order2_r4: assert property (@(posedge clk) disable iff (!rstN)
    sramWrEn[1] |=> sramWrEn[2] && $stable(sramAddr));

  p_no_mixed_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoWrEn && (sramWrEn != 3'b000)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    idleRdy |-> !fifoWrEn && (sramWrEn == 3'b000));

  p_rd_paced_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRdEn || sramRdEn) |-> outReady);

  p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(fifoRdEn || sramRdEn, 2));

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(idleRdy && dataAvail));
endmodule

bind dbgcap_top dbgcap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn),
  .sramAddr(sramAddr), .sramWrEn(sramWrEn), .sramRdEn(sramRdEn),
  .outReady(outReady), .outValid(outValid), .idleRdy(idleRdy),
  .dataAvail(dataAvail)
);

// File: tb/dbgcap_top_bench.sv
module dbgcap_top_bench;
  localparam int AW  = 4;
  localparam int NW  = 1 << AW;
  localparam int NST = 6 * NW + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic modeSram = 1'b0;
  logic [19:0] dbgData = '0;
  logic fifoWrEn, fifoRdEn, sramRdEn, outValid, idleRdy, dataAvail;
  logic [17:0] fifoWrData;
  logic [17:0] fifoRdData = '0;
  logic [AW-1:0] sramAddr;
  logic [2:0] sramWrEn;
  logic [7:0] sramWrData;
  logic [23:0] sramRdData = '0;
  logic outReady = 1'b0;
  logic [23:0] outWord;

  always #5 clk = ~clk;

  dbgcap_top #(.ADDR_W(AW)) u_dbgcap_top (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeSram(modeSram),
    .dbgData(dbgData), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData), .sramAddr(sramAddr),
    .sramWrEn(sramWrEn), .sramWrData(sramWrData), .sramRdEn(sramRdEn),
    .sramRdData(sramRdData), .outReady(outReady), .outWord(outWord),
    .outValid(outValid), .idleRdy(idleRdy), .dataAvail(dataAvail)
  );

  // store models
  logic memClr = 1'b0;
  logic [17:0] fifoMem [NW];
  logic [7:0]  laneMem [3][NW];
  int fifoWp, fifoRp;
  int laneCnt [3];

  always @(posedge clk) begin
    if (memClr) begin
      fifoWp <= 0;
      fifoRp <= 0;
      for (int i = 0; i < 3; i++) laneCnt[i] <= 0;
    end else begin
      if (fifoWrEn) begin
        fifoMem[fifoWp % NW] <= fifoWrData;
        fifoWp <= fifoWp + 1;
      end
      if (fifoRdEn) begin
        fifoRdData <= fifoMem[fifoRp % NW];
        fifoRp <= fifoRp + 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (sramWrEn[i]) begin
          laneMem[i][sramAddr] <= sramWrData;
          laneCnt[i] <= laneCnt[i] + 1;
        end
      end
      if (sramRdEn) sramRdData <= {laneMem[2][sramAddr], laneMem[1][sramAddr], laneMem[0][sramAddr]};
    end
  end

  int vectors = 0;
  int miscompares = 0;
  logic [19:0] stim [NST];
  logic [23:0] rdWords [NW];
  int rdCnt;

  function automatic logic [23:0] expFifo(input logic [19:0] s);
    return {{6{s[19]}}, s[19:2]};
  endfunction

  function automatic logic [23:0] expSram(input logic [19:0] s);
    return {{4{s[19]}}, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fillStim(input int kind);
    for (int k = 0; k < NST; k++) begin
      if (kind == 0) stim[k] = 20'($urandom);
      else case (k % 4)
        0: stim[k] = 20'h80000;
        1: stim[k] = 20'h7FFFF;
        2: stim[k] = 20'hFFFFF;
        default: stim[k] = 20'h00001;
      endcase
    end
  endtask

  task automatic runCapture(input bit sram, input bit disturb);
    int total;
    total = sram ? 6 * NW : NW;
    outReady = 1'b0;
    @(negedge clk) memClr = 1'b1;
    @(negedge clk) memClr = 1'b0;
    modeSram = sram;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    dbgData = stim[0];
    for (int k = 1; k < total + 4; k++) begin
      @(negedge clk);
      dbgData = stim[k];
      if (disturb && k == 10) begin
        modeSram = !sram;
        startPulse = 1'b1;
      end else if (disturb && k == 11) begin
        modeSram = sram;
        startPulse = 1'b0;
      end
    end
    check("R5 dataAvail after capture", 32'(dataAvail), 32'd1);
    check("R5 idleRdy low after capture", 32'(idleRdy), 32'd0);
    if (sram) begin
      for (int i = 0; i < 3; i++) check("R3 lane write count", 32'(laneCnt[i]), 32'(NW));
      check("R10 no FIFO writes in RAM mode", 32'(fifoWp), 32'd0);
      for (int k = 0; k < NW; k++) begin
        check("R4 lane bytes", {8'h0, laneMem[2][k], laneMem[1][k], laneMem[0][k]},
              {8'h0, expSram(stim[6 * k])});
      end
    end else begin
      check("R2 R5 FIFO write count", 32'(fifoWp), 32'(NW));
      for (int i = 0; i < 3; i++) check("R10 no lane writes in FIFO mode", 32'(laneCnt[i]), 32'd0);
      for (int k = 0; k < NW; k++) check("R2 FIFO entry", 32'(fifoMem[k]), 32'(stim[k][19:2]));
    end
  endtask

  task automatic readAll(input bit sram, input bit pokeStart);
    bit done;
    int wpBefore;
    rdCnt = 0;
    done = 1'b0;
    for (int it = 0; it < 2000 && !done; it++) begin
      @(negedge clk);
      outReady = ($urandom % 4) != 0;
      startPulse = pokeStart && (it == 7);
      #1;
      if (!outReady && (fifoRdEn || sramRdEn))
        check("R7 read strobe without ready", 32'd1, 32'd0);
      if (outValid) begin
        if (rdCnt < NW) rdWords[rdCnt] = outWord;
        rdCnt++;
        if (rdCnt == NW) begin
          check("R8 dataAvail low at last word", 32'(dataAvail), 32'd0);
          check("R8 idleRdy at last word", 32'(idleRdy), 32'd1);
          done = 1'b1;
        end
      end
    end
    startPulse = 1'b0;
    outReady = 1'b0;
    check("R6 readout word count", 32'(rdCnt), 32'(NW));
    for (int k = 0; k < NW; k++) begin
      check("R6 readout word", 32'(rdWords[k]),
            32'(sram ? expSram(stim[6 * k]) : expFifo(stim[k])));
    end
    wpBefore = fifoWp + laneCnt[0];
    repeat (8) @(negedge clk);
    check("R9 no restart after readout", 32'(fifoWp + laneCnt[0]), 32'(wpBefore));
    check("R9 idle after readout", 32'(idleRdy), 32'd1);
  endtask

  task automatic mainFlow();
    void'($urandom(32'h1F2E3D));
    repeat (3) @(negedge clk);
    check("R1 idleRdy", 32'(idleRdy), 32'd1);
    check("R1 dataAvail", 32'(dataAvail), 32'd0);
    check("R1 outValid", 32'(outValid), 32'd0);
    check("R1 fifoWrEn", 32'(fifoWrEn), 32'd0);
    check("R1 sramWrEn", 32'(sramWrEn), 32'd0);
    @(negedge clk) rstN = 1'b1;
    // FIFO random
    fillStim(0);
    runCapture(1'b0, 1'b0);
    readAll(1'b0, 1'b0);
    // RAM random with start and mode disturbance during capture (R9)
    fillStim(0);
    runCapture(1'b1, 1'b1);
    readAll(1'b1, 1'b0);
    // RAM corner values, start pulse during readout (R9)
    fillStim(1);
    runCapture(1'b1, 1'b0);
    readAll(1'b1, 1'b1);
    // FIFO corner values with disturbance (R6 sign extension, R9)
    fillStim(1);
    runCapture(1'b0, 1'b1);
    readAll(1'b0, 1'b1);
  endtask

  initial begin
    fork
      mainFlow();
      begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule